// File: doc/BRIEF.md
# Host Bus Byte-Lane Slave

This block is the slave side of an asynchronous host bus with sixteen data lines, a four-bit register address, and active-low chip select, read and write strobes. It holds sixteen byte-wide registers. A 16-bit host reaches them as even/odd byte pairs, or one byte at a time on either half of the data bus. An 8-bit host reaches every register on the low lanes only. The lane decision comes from the active-low high-enable line, address bit 0, and a width-mode bit kept in one of the registers.

Strobes are asynchronous, so they pass through a two-stage synchronizer. A three-state machine then answers each access:
- `ST_IDLE` moves to `ST_WR_HOLD` when a write alone is seen. The selected bytes are written on that same edge.
- `ST_IDLE` moves to `ST_RD_HOLD` when a read alone is seen.
- Either hold state returns to `ST_IDLE` once its strobe is seen released.
- When a read and a write are seen together, the machine stays in `ST_IDLE`.

The ready output is asserted in both hold states, at the level chosen by a polarity pin. The bus-width pin mirrors the width mode. An end-of-process input is translated to an active-high flag whose input polarity is set by a second configuration bit.

Top module: `hbl_host_if`

## Requirements
- R1: After reset all sixteen registers read zero. The block is in 16-bit mode, `wide_bus` is 1, ready is at its inactive level, and `bus_data` floats.
- R2: In 16-bit mode, `bus_hi_en_n`=0 with `bus_addr[0]`=0 is a word access. `bus_data[7:0]` maps to register `bus_addr` and `bus_data[15:8]` maps to register `bus_addr`+1.
- R3: In 16-bit mode, `bus_hi_en_n`=0 with `bus_addr[0]`=1 is an upper-byte access. Register `bus_addr` maps to `bus_data[15:8]`. A write leaves every other register unchanged, and a read drives `bus_data[7:0]` to zero.
- R4: In 16-bit mode, `bus_hi_en_n`=1 with `bus_addr[0]`=0 is a lower-byte access. Register `bus_addr` maps to `bus_data[7:0]`, and a read drives `bus_data[15:8]` to zero.
- R5: In 16-bit mode, `bus_hi_en_n`=1 with `bus_addr[0]`=1 is reserved. A write changes no register, a read returns zero on both lanes, and ready still completes the cycle.
- R6: Bit 0 of register 14 set to 1 selects 8-bit mode. In this mode `bus_hi_en_n` and `bus_addr[0]` are ignored, every access moves register `bus_addr` on `bus_data[7:0]`, and reads drive `bus_data[15:8]` to zero.
- R7: `wide_bus` equals the inverse of bit 0 of register 14.
- R8: Ready is asserted at the level of `rdy_pol` (low when 0, high when 1) and otherwise rests at the opposite level.
- R9: Ready asserts after the third rising clock edge that follows a strobe assertion, and a write commits on that edge. Ready drops after the third rising edge that follows strobe release.
- R10: `bus_data` floats whenever `bus_cs_n` or `bus_rd_n` is high.
- R11: `eop_hit` is 1 when `eop_in` equals the asserted level. That level is high when bit 1 of register 14 is 1 and low when it is 0.
- R12: When read and write strobes are seen together, no transfer happens and ready stays inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_addr | input | 4 | Register address |
| bus_hi_en_n | input | 1 | High-lane enable, active low |
| bus_data | inout | 16 | Host data bus |
| rdy_pol | input | 1 | Ready polarity strap: 1 = active high |
| bus_ready | output | 1 | Ready to complete the cycle |
| wide_bus | output | 1 | 1 = 16-bit mode, 0 = 8-bit mode |
| eop_in | input | 1 | End-of-process input, programmable level |
| eop_hit | output | 1 | End of process asserted, active high |

## Verification
- **Read data:** read data and the floating of `bus_data` follow the pins within the same cycle, so they are sampled at the falling edge after the third edge, while the strobe is still held.
- **Ready timing:** with two synchronizer stages and one state register, ready is due exactly after the third rising edge past strobe assertion. Every bus cycle checks ready inactive after the second edge and active after the third. On release it checks ready still active after the second edge and inactive after the third.
- **Write commit:** writes are confirmed only through later reads on the port.
- **Combinational outputs:** `wide_bus` and `eop_hit` are combinational, so they are checked at the first falling edge after the configuration write completes or `eop_in` changes.

// File: rtl/hbl_pkg.sv
package hbl_pkg;

    localparam int BYTE_W        = 8;
    localparam int CFG_NARROW_IX = 0;
    localparam int CFG_EOPHI_IX  = 1;

    typedef enum logic [1:0] {
        LANE_NONE = 2'd0,
        LANE_LOW  = 2'd1,
        LANE_HIGH = 2'd2,
        LANE_WORD = 2'd3
    } lane_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RD_HOLD = 2'd1,
        ST_WR_HOLD = 2'd2
    } bus_state_e;

endpackage

// File: rtl/hbl_strobe_sync.sv
module hbl_strobe_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[i] <= '0;
                else        stg[i] <= stg[i-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hbl_lane_decode.sv
module hbl_lane_decode
    import hbl_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              hi_en_n,
    input  logic              narrow,
    output lane_e             lane,
    output logic              lo_en,
    output logic              hi_en,
    output logic [ADDR_W-1:0] lo_idx,
    output logic [ADDR_W-1:0] hi_idx
);
    always_comb begin
        if (narrow) begin
            lane = LANE_LOW;
        end else begin
            unique case ({hi_en_n, addr[0]})
                2'b00:   lane = LANE_WORD;
                2'b01:   lane = LANE_HIGH;
                2'b10:   lane = LANE_LOW;
                default: lane = LANE_NONE;
            endcase
        end
    end

    assign lo_en  = (lane == LANE_LOW)  || (lane == LANE_WORD);
    assign hi_en  = (lane == LANE_HIGH) || (lane == LANE_WORD);
    assign lo_idx = addr;
    // word: even address + 1; upper byte: address is already odd
    assign hi_idx = {addr[ADDR_W-1:1], 1'b1};
endmodule

// File: rtl/hbl_regfile.sv
module hbl_regfile
    import hbl_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int CFG_ADDR = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic              lo_en,
    input  logic              hi_en,
    input  logic [ADDR_W-1:0] lo_idx,
    input  logic [ADDR_W-1:0] hi_idx,
    input  logic [2*BYTE_W-1:0] wdata,
    output logic [2*BYTE_W-1:0] rdata,
    output logic              narrow,
    output logic              eop_hi
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (we_lo) mem[lo_idx] <= wdata[BYTE_W-1:0];
            if (we_hi) mem[hi_idx] <= wdata[2*BYTE_W-1:BYTE_W];
        end
    end

    always_comb begin
        rdata[BYTE_W-1:0]        = lo_en ? mem[lo_idx] : '0;
        rdata[2*BYTE_W-1:BYTE_W] = hi_en ? mem[hi_idx] : '0;
    end

    assign narrow = mem[CFG_ADDR][CFG_NARROW_IX];
    assign eop_hi = mem[CFG_ADDR][CFG_EOPHI_IX];
endmodule

// File: rtl/hbl_bus_fsm.sv
module hbl_bus_fsm
    import hbl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd_seen,
    input  logic       wr_seen,
    output bus_state_e state,
    output logic       commit,
    output logic       ack
);
    bus_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (wr_seen && !rd_seen)      nxt = ST_WR_HOLD;
                else if (rd_seen && !wr_seen) nxt = ST_RD_HOLD;
            end
            ST_RD_HOLD: if (!rd_seen) nxt = ST_IDLE;
            ST_WR_HOLD: if (!wr_seen) nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        commit = (state == ST_IDLE) && (nxt == ST_WR_HOLD);
        ack    = (state != ST_IDLE);
    end

    // R9
    ack_after_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> $past(rd_seen || wr_seen));

    // R12
    clash_stays_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && rd_seen && wr_seen) |=> (state == ST_IDLE));
endmodule

// File: rtl/hbl_host_if.sv
module hbl_host_if
    import hbl_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int CFG_ADDR    = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_cs_n,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_hi_en_n,
    inout  wire  [15:0]       bus_data,
    input  logic              rdy_pol,
    output logic              bus_ready,
    output logic              wide_bus,
    input  logic              eop_in,
    output logic              eop_hit
);
    localparam int DATA_W = 2 * BYTE_W;

    logic              narrow, eop_hi;
    lane_e             lane;
    logic              lo_en, hi_en;
    logic [ADDR_W-1:0] lo_idx, hi_idx;
    logic [1:0]        req_raw, req_seen;
    logic              commit, ack;
    bus_state_e        state;
    logic [DATA_W-1:0] rdata;
    logic              drive;

    assign req_raw = {~bus_cs_n & ~bus_wr_n, ~bus_cs_n & ~bus_rd_n};

    hbl_strobe_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(req_raw), .q(req_seen)
    );

    hbl_bus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .rd_seen(req_seen[0]), .wr_seen(req_seen[1]),
        .state(state), .commit(commit), .ack(ack)
    );

    hbl_lane_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr(bus_addr), .hi_en_n(bus_hi_en_n), .narrow(narrow),
        .lane(lane), .lo_en(lo_en), .hi_en(hi_en),
        .lo_idx(lo_idx), .hi_idx(hi_idx)
    );

    hbl_regfile #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .we_lo(commit & lo_en), .we_hi(commit & hi_en),
        .lo_en(lo_en), .hi_en(hi_en),
        .lo_idx(lo_idx), .hi_idx(hi_idx),
        .wdata(bus_data), .rdata(rdata),
        .narrow(narrow), .eop_hi(eop_hi)
    );

    assign drive     = ~bus_cs_n & ~bus_rd_n;
    assign bus_data  = drive ? rdata : {DATA_W{1'bz}};
    assign bus_ready = ack ? rdy_pol : ~rdy_pol;
    assign wide_bus  = ~narrow;
    assign eop_hit   = eop_hi ? eop_in : ~eop_in;

    // R5
    reserved_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && lane == LANE_NONE) |-> (!lo_en && !hi_en));

    // R6
    narrow_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        narrow |-> (!hi_en && lo_en && lo_idx == bus_addr));

    // R2
    word_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_en && hi_en) |-> (!lo_idx[0] &&
            hi_idx == lo_idx + {{(ADDR_W-1){1'b0}}, 1'b1}));

    // R8
    ready_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (bus_ready != rdy_pol));
endmodule

// File: tb/sim_hbl_host_if.sv
`timescale 1ns/1ps
module sim_hbl_host_if;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_hi_en_n = 1'b1;
    logic        rdy_pol = 1'b1;
    logic        eop_in = 1'b0;
    logic        tb_oe = 1'b0;
    logic [15:0] tb_drv = '0;
    wire  [15:0] bus_data;
    logic        bus_ready, wide_bus, eop_hit;
    int          n_chk = 0, n_fail = 0;
    logic [15:0] rd;

    assign bus_data = tb_oe ? tb_drv : 16'hzzzz;

    always #2 clk = ~clk;

    hbl_host_if u0 (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
        .bus_wr_n(bus_wr_n), .bus_addr(bus_addr), .bus_hi_en_n(bus_hi_en_n),
        .bus_data(bus_data), .rdy_pol(rdy_pol), .bus_ready(bus_ready),
        .wide_bus(wide_bus), .eop_in(eop_in), .eop_hit(eop_hit)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_cycle(input bit is_wr, input logic [3:0] a, input bit hen_n,
                             input logic [15:0] wd, output logic [15:0] rdv);
        @(negedge clk);
        bus_addr = a; bus_hi_en_n = hen_n;
        if (is_wr) begin tb_drv = wd; tb_oe = 1'b1; end
        bus_cs_n = 1'b0;
        if (is_wr) bus_wr_n = 1'b0; else bus_rd_n = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R9 ready early", {15'd0, bus_ready}, {15'd0, ~rdy_pol});
        @(posedge clk); @(negedge clk);
        chk("R8 R9 ready on", {15'd0, bus_ready}, {15'd0, rdy_pol});
        rdv = bus_data;
        bus_cs_n = 1'b1; bus_rd_n = 1'b1; bus_wr_n = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R9 ready held", {15'd0, bus_ready}, {15'd0, rdy_pol});
        @(posedge clk); @(negedge clk);
        chk("R9 ready off", {15'd0, bus_ready}, {15'd0, ~rdy_pol});
        tb_oe = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 wide_bus", {15'd0, wide_bus}, 16'd1);
        chk("R1 ready idle", {15'd0, bus_ready}, 16'd0);
        chk("R1 float", bus_data, 16'hzzzz);
        eop_in = 1'b1; #1;
        chk("R11 reset eop", {15'd0, eop_hit}, 16'd0);
        eop_in = 1'b0;
        for (int a = 0; a < 16; a += 2) begin
            bus_cycle(0, 4'(a), 1'b0, 16'h0, rd);
            chk("R1 reg zero", rd, 16'h0000);
        end
    endtask

    task automatic t_word();
        bus_cycle(1, 4'd4, 1'b0, 16'hBEEF, rd);
        bus_cycle(0, 4'd4, 1'b0, 16'h0, rd);
        chk("R2 word read", rd, 16'hBEEF);
    endtask

    task automatic t_upper();
        bus_cycle(1, 4'd5, 1'b0, 16'h1234, rd);
        bus_cycle(0, 4'd4, 1'b0, 16'h0, rd);
        chk("R3 upper write", rd, 16'h12EF);
        bus_cycle(0, 4'd5, 1'b0, 16'h0, rd);
        chk("R3 upper read", rd, 16'h1200);
    endtask

    task automatic t_lower();
        bus_cycle(1, 4'd6, 1'b1, 16'h5678, rd);
        bus_cycle(0, 4'd6, 1'b0, 16'h0, rd);
        chk("R4 lower write", rd, 16'h0078);
        bus_cycle(0, 4'd4, 1'b1, 16'h0, rd);
        chk("R4 lower read", rd, 16'h00EF);
    endtask

    task automatic t_reserved();
        bus_cycle(1, 4'd5, 1'b1, 16'hFFFF, rd);
        bus_cycle(0, 4'd4, 1'b0, 16'h0, rd);
        chk("R5 no write", rd, 16'h12EF);
        bus_cycle(0, 4'd5, 1'b1, 16'h0, rd);
        chk("R5 read zero", rd, 16'h0000);
    endtask

    task automatic t_clash();
        @(negedge clk);
        bus_addr = 4'd4; bus_hi_en_n = 1'b0;
        bus_cs_n = 1'b0; bus_rd_n = 1'b0; bus_wr_n = 1'b0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R12 no ready", {15'd0, bus_ready}, {15'd0, ~rdy_pol});
        bus_cs_n = 1'b1; bus_rd_n = 1'b1; bus_wr_n = 1'b1;
        repeat (4) @(posedge clk);
        bus_cycle(0, 4'd4, 1'b0, 16'h0, rd);
        chk("R12 unchanged", rd, 16'h12EF);
    endtask

    task automatic t_float();
        @(negedge clk);
        bus_cs_n = 1'b1; bus_rd_n = 1'b0; #1;
        chk("R10 cs high", bus_data, 16'hzzzz);
        bus_cs_n = 1'b0; bus_rd_n = 1'b1; #1;
        chk("R10 rd high", bus_data, 16'hzzzz);
        bus_cs_n = 1'b1;
        repeat (4) @(posedge clk);
    endtask

    task automatic t_polarity();
        rdy_pol = 1'b0;
        @(negedge clk);
        chk("R8 low-active idle", {15'd0, bus_ready}, 16'd1);
        bus_cycle(0, 4'd4, 1'b0, 16'h0, rd);
        chk("R8 read ok", rd, 16'h12EF);
        rdy_pol = 1'b1;
    endtask

    task automatic t_narrow();
        bus_cycle(1, 4'd14, 1'b1, 16'h0001, rd);
        @(negedge clk);
        chk("R7 narrow", {15'd0, wide_bus}, 16'd0);
        bus_cycle(1, 4'd3, 1'b0, 16'hAB55, rd);
        bus_cycle(0, 4'd3, 1'b0, 16'h0, rd);
        chk("R6 odd low lane", rd, 16'h0055);
        bus_cycle(0, 4'd5, 1'b0, 16'h0, rd);
        chk("R6 ignore hi_en", rd, 16'h0012);
        bus_cycle(1, 4'd14, 1'b0, 16'h0000, rd);
        @(negedge clk);
        chk("R7 wide again", {15'd0, wide_bus}, 16'd1);
        bus_cycle(0, 4'd2, 1'b0, 16'h0, rd);
        chk("R6 byte placed", rd, 16'h5500);
    endtask

    task automatic t_eop();
        bus_cycle(1, 4'd14, 1'b1, 16'h0002, rd);
        eop_in = 1'b1; #1;
        chk("R11 high active on", {15'd0, eop_hit}, 16'd1);
        chk("R7 mode kept", {15'd0, wide_bus}, 16'd1);
        eop_in = 1'b0; #1;
        chk("R11 high active off", {15'd0, eop_hit}, 16'd0);
        bus_cycle(1, 4'd14, 1'b1, 16'h0000, rd);
        #1;
        chk("R11 low active on", {15'd0, eop_hit}, 16'd1);
        eop_in = 1'b1; #1;
        chk("R11 low active off", {15'd0, eop_hit}, 16'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_word();
        t_upper();
        t_lower();
        t_reserved();
        t_clash();
        t_float();
        t_polarity();
        t_narrow();
        t_eop();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule